// File: doc/BRIEF.md
# Timer Clock Select Prescaler

This block produces the count-enable strobe that advances a timer counter. A 3-bit select input picks the source of that strobe. The strobe can be stopped, or it can fire on every system clock. It can also fire at one of four fixed divide ratios (8, 64, 256 or 1024), which are taken from a free-running 10-bit prescale counter. The last two choices follow a falling or a rising edge on an external pin.

The external pin is asynchronous to the system clock. It passes through a two-flop synchroniser, and the synchronised level is edge-detected. Each qualifying edge then gives exactly one strobe cycle. The strobe is registered, so the select value in force at a clock edge decides the strobe for the cycle that follows. The prescale count is brought out for debug. The timer counter that consumes the strobe lives elsewhere.

Top module: `tmr_clksel_prescaler`

## Requirements
- R1: While `rst_n` is low, `tick` is 0 and `presc_cnt` is 0.
- R2: `presc_cnt` rises by one on every clock edge out of reset and wraps from 1023 to 0, whatever `sel` holds.
- R3: With `sel` = 3'b000 (stop), `tick` is 0 in the cycle after each edge that sampled that code, and external pin edges have no effect.
- R4: With `sel` = 3'b001, `tick` is 1 in the cycle after every edge that sampled that code.
- R5: With `sel` = 3'b010, 3'b011, 3'b100 or 3'b101 (divide by 8, 64, 256 or 1024, that is k = 3, 6, 8 or 10), `tick` is 1 for exactly the cycles that follow an edge at which the low k bits of `presc_cnt` were all ones. This is one strobe per N clocks.
- R6: With `sel` = 3'b110, each falling edge of `ext_in` gives one `tick` cycle. It appears after the third clock edge that follows the pin change.
- R7: With `sel` = 3'b111, each rising edge of `ext_in` gives one `tick` cycle, with the same latency as in R6.
- R8: A change of `sel` takes effect at the next clock edge. The strobe in any cycle depends only on the select value sampled at the edge before it, so a switch causes no extra strobe.
- R9: While an external code is held, `tick` never stays high for two consecutive cycles. Pin levels held for at least two clocks are each counted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel | input | 3 | Strobe source select code |
| ext_in | input | 1 | Asynchronous external clock pin |
| tick | output | 1 | Single-cycle count-enable strobe |
| presc_cnt | output | 10 | Free-running prescale count (debug) |

## Verification
The assertions check the following on every cycle:
- the counter steps by one;
- the stop and every-clock codes;
- the divide-by-8 hit and miss pattern and the divide-by-1024 hit;
- the rule that an external strobe never repeats while its code is held.

Edge counting on the external pin needs scenarios from the bench, and so does the three-edge synchroniser latency. Two further points also need those scenarios. One is that pin activity under the stop code leaves no trace. The other is that rapid select switching yields exactly the strobes the sampled codes call for. A cycle-level reference model in the bench covers these, backed by strobe counts over fixed windows.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    CS_STOP     = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } cs_sel_e;

  localparam int unsigned CS_NUM_DIV = 4;

  // Divide exponent for divider slot i (slot 0 is code 3'b010).
  function automatic int unsigned cs_div_log2(input int unsigned slot);
    case (slot)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tcs_prescale_ctr.sv
module tcs_prescale_ctr #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              lvl;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        assign sync_d[s] = pin;
      end else begin : g_next
        assign sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= lvl;
    end
  end

  always_comb begin
    rise = lvl & ~last_q;
    fall = ~lvl & last_q;
  end

endmodule

// File: rtl/tcs_tick_sel.sv
module tcs_tick_sel
  import tcs_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] cnt,
  input  logic         rise,
  input  logic         fall,
  output logic         tick_d
);

  cs_sel_e               code;
  logic [CS_NUM_DIV-1:0] div_hit;

  assign code = cs_sel_e'(sel);

  generate
    for (genvar i = 0; i < CS_NUM_DIV; i++) begin : g_div
      localparam int unsigned L = cs_div_log2(i);
      assign div_hit[i] = &cnt[L-1:0];
    end
  endgenerate

  always_comb begin
    case (code)
      CS_STOP:     tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_DIV8:     tick_d = div_hit[0];
      CS_DIV64:    tick_d = div_hit[1];
      CS_DIV256:   tick_d = div_hit[2];
      CS_DIV1024:  tick_d = div_hit[3];
      CS_EXT_FALL: tick_d = fall;
      CS_EXT_RISE: tick_d = rise;
      default:     tick_d = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_clksel_prescaler.sv
module tmr_clksel_prescaler #(
  parameter int unsigned PRESC_W     = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         sel,
  input  logic               ext_in,
  output logic               tick,
  output logic [PRESC_W-1:0] presc_cnt
);

  logic [PRESC_W-1:0] cnt;
  logic               ext_rise;
  logic               ext_fall;
  logic               tick_d;
  logic               tick_q;

  tcs_prescale_ctr #(.W(PRESC_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt)
  );

  tcs_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  tcs_tick_sel #(.W(PRESC_W)) u_sel (
    .sel    (sel),
    .cnt    (cnt),
    .rise   (ext_rise),
    .fall   (ext_fall),
    .tick_d (tick_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick      = tick_q;
  assign presc_cnt = cnt;

endmodule

// File: rtl/tcs_prescaler_chk.sv
module tcs_prescaler_chk #(
  parameter int unsigned PRESC_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         sel,
  input logic               tick,
  input logic [PRESC_W-1:0] presc_cnt
);

  // R2
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> presc_cnt == $past(presc_cnt) + {{(PRESC_W-1){1'b0}}, 1'b1});

  // R3
  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'b000 |=> !tick);

  // R4
  p_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'b001 |=> tick);

  // R5
  p_div8_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b010 && presc_cnt[2:0] == 3'b111) |=> tick);

  p_div8_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b010 && presc_cnt[2:0] != 3'b111) |=> !tick);

  p_div1024_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b101 && presc_cnt[9:0] == 10'h3FF) |=> tick);

  // R9
  p_ext_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11 && sel == $past(sel) && tick) |=> !tick);

endmodule

bind tmr_clksel_prescaler tcs_prescaler_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .tick      (tick),
  .presc_cnt (presc_cnt)
);

// File: tb/test_tmr_clksel_prescaler.sv
`timescale 1ns/1ps
module test_tmr_clksel_prescaler;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       ext_in;
  logic       tick;
  logic [9:0] presc_cnt;

  int checks = 0;
  int errors = 0;
  int tick_count = 0;

  always #2.5 clk = ~clk;

  tmr_clksel_prescaler i_tmr_clksel_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .ext_in    (ext_in),
    .tick      (tick),
    .presc_cnt (presc_cnt)
  );

  typedef struct {
    logic       tick;
    logic [9:0] cnt;
    logic [2:0] sel;
    logic       changed;
  } exp_t;

  exp_t expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: predicts the strobe and count for the cycle after each edge.
  int         m_cnt;
  logic       m_s1, m_s2, m_s3, e;
  logic [2:0] m_prev_sel;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_prev_sel = 3'b000;
      expq.delete();
    end else begin
      case (sel)
        3'b000: e = 1'b0;
        3'b001: e = 1'b1;
        3'b010: e = (m_cnt % 8) == 7;
        3'b011: e = (m_cnt % 64) == 63;
        3'b100: e = (m_cnt % 256) == 255;
        3'b101: e = (m_cnt % 1024) == 1023;
        3'b110: e = !m_s2 && m_s3;
        default: e = m_s2 && !m_s3;
      endcase
      expq.push_back('{tick: e, cnt: 10'((m_cnt + 1) % 1024), sel: sel,
                       changed: sel != m_prev_sel});
      m_prev_sel = sel;
      m_cnt = (m_cnt + 1) % 1024;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
    end
  end

  function automatic string req_of(input logic [2:0] s, input logic changed);
    if (changed) return "R8";
    case (s)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b110: return "R6";
      3'b111: return "R7";
      default: return "R5";
    endcase
  endfunction

  // Monitor: pops each prediction and compares at the falling edge.
  always @(negedge clk) begin
    if (rst_n && expq.size() > 0) begin
      exp_t it;
      it = expq.pop_front();
      chk(tick === it.tick, req_of(it.sel, it.changed), "tick", int'(tick), int'(it.tick));
      chk(presc_cnt === it.cnt, "R2", "presc_cnt", int'(presc_cnt), int'(it.cnt));
      if (tick === 1'b1) tick_count++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_sel(input logic [2:0] s);
    sel = s;
    cyc(1);
    tick_count = 0;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; cyc(hi);
      ext_in = 1'b0; cyc(lo);
    end
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    cyc(3);
    chk(tick === 1'b0, "R1", "tick in reset", int'(tick), 0);
    chk(presc_cnt === 10'd0, "R1", "presc_cnt in reset", int'(presc_cnt), 0);
    rst_n = 1'b1;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 3'b000; ext_in = 1'b0;
    #1;
    reset_check();

    set_sel(3'b000); cyc(40);
    chk(tick_count == 0, "R3", "ticks while stopped", tick_count, 0);
    set_sel(3'b001); cyc(30);
    chk(tick_count == 30, "R4", "ticks every clock", tick_count, 30);
    set_sel(3'b010); cyc(96);
    chk(tick_count == 12, "R5", "div8 ticks in 96", tick_count, 12);
    set_sel(3'b011); cyc(320);
    chk(tick_count == 5, "R5", "div64 ticks in 320", tick_count, 5);
    set_sel(3'b100); cyc(768);
    chk(tick_count == 3, "R5", "div256 ticks in 768", tick_count, 3);
    set_sel(3'b101); cyc(2048);
    chk(tick_count == 2, "R5", "div1024 ticks in 2048", tick_count, 2);

    // R8: rapid switching, every code in turn
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++) begin
        sel = 3'(c); cyc(1 + (c % 3));
      end

    set_sel(3'b111); cyc(4);
    tick_count = 0;
    pulses(6, 2, 3); cyc(5);
    chk(tick_count == 6, "R7", "R9 rising edges counted once", tick_count, 6);
    set_sel(3'b110); cyc(4);
    tick_count = 0;
    pulses(7, 3, 2); cyc(5);
    chk(tick_count == 7, "R6", "R9 falling edges counted once", tick_count, 7);
    set_sel(3'b000); cyc(4);
    tick_count = 0;
    pulses(5, 2, 2); cyc(5);
    chk(tick_count == 0, "R3", "pin edges ignored when stopped", tick_count, 0);

    // Pin toggles while the select alternates between the external codes
    for (int i = 0; i < 6; i++) begin
      sel = (i % 2 == 0) ? 3'b111 : 3'b110;
      ext_in = ~ext_in; cyc(2);
    end
    ext_in = 1'b0;
    sel = 3'b001; cyc(20);
    sel = 3'b000;
    #1;
    reset_check();
    set_sel(3'b010); cyc(16);
    chk(tick_count == 2, "R5", "div8 after second reset", tick_count, 2);
    cyc(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule